// File: doc/BRIEF.md
# Two-Port Hardware Semaphore Bank

This block holds a small set of single-bit ownership latches that two independent requesters, a left port and a right port, use to reserve shared resources. A port asks for a token by writing 0 to a latch, and gives it back or withdraws its claim by writing 1. It then reads the same latch to learn whether it holds the token. A reading of 0 means the token is held by the reading port. A reading of 1 means the latch is free or is held by the other side.

Each latch keeps its current owner and one pending claim from the non-owning port. When the owner releases, the token passes straight to the waiting port. If both ports claim a free latch in the same cycle, the left port wins and the right port's claim stays pending. Reads come out of a per-port output register. A write from the other port in the same cycle therefore cannot alter the value being returned.

Top module: `sem_bank`

## Requirements
- R1: After reset all eight latches are free, and both read-data outputs show all ones (9'h1FF).
- R2: The 3-bit index selects one of eight latches. Index value n addresses latch n on both ports.
- R3: A write with select=1, write=1 and wdat=0 to a free latch gives the token to the writer. The owner then reads 0 and the other port reads 1.
- R4: A write of 0 from a port while the other port holds the token leaves both readbacks unchanged and records a pending claim.
- R5: When the owner writes 1 while the other port has a pending claim, the other port becomes owner in the same update. It then reads 0, and the releasing port reads 1.
- R6: When the owner writes 1 and no claim is pending, the latch becomes free and both ports read 1.
- R7: A pending claim is withdrawn when the claiming port writes 1. A later release by the owner then leaves the latch free.
- R8: A write of 1 from a port that neither holds the latch nor has a claim pending on it changes nothing.
- R9: When both ports write 0 to the same free latch in one cycle, the left port becomes owner and the right port's claim stays pending.
- R10: A read (select=1, write=0) updates the port's read data one clock edge later. The value reflects the latch state before any write in that same cycle. Without a read, the read data holds its last value.
- R11: All nine read-data bits carry the same value: all zeros for the owner, all ones otherwise.
- R12: A write to one latch never changes the state or readback of any other latch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| l_sel | input | 1 | Left port semaphore select |
| l_wr | input | 1 | Left port write (1) or read (0) |
| l_idx | input | 3 | Left port latch index |
| l_wdat | input | 1 | Left port write data: 0 claim, 1 release |
| l_rdat | output | 9 | Left port registered read data |
| r_sel | input | 1 | Right port semaphore select |
| r_wr | input | 1 | Right port write (1) or read (0) |
| r_idx | input | 3 | Right port latch index |
| r_wdat | input | 1 | Right port write data: 0 claim, 1 release |
| r_rdat | output | 9 | Right port registered read data |

## Verification
Two functions can land in the same cycle: an owner's release and the other port's claim or cancel on the same latch, and one port's read while the other port writes that latch. The bench provokes both. It uses directed steps and also a long pseudo-random sweep that steers both ports onto the same index half the time. A behavioural model of owner and pending claim, updated once per cycle, judges the results. Readback is checked on both ports every cycle against the model state taken before that cycle's writes.

// File: rtl/sem_bank_pkg.sv
package sem_bank_pkg;

  typedef enum logic [1:0] {
    SEM_FREE  = 2'd0,
    SEM_LEFT  = 2'd1,
    SEM_RIGHT = 2'd2
  } owner_t;

endpackage

// File: rtl/sem_port_dec.sv
module sem_port_dec #(
  parameter int NUM_SEM = 8,
  localparam int IDX_W  = $clog2(NUM_SEM)
) (
  input  logic               sel,
  input  logic               wr,
  input  logic [IDX_W-1:0]   idx,
  input  logic               wdat,
  output logic [NUM_SEM-1:0] req_vec,
  output logic [NUM_SEM-1:0] rel_vec,
  output logic               rd_en
);

  logic wr_en;

  assign wr_en = sel & wr;
  assign rd_en = sel & ~wr;

  for (genvar i = 0; i < NUM_SEM; i++) begin : g_dec
    logic hit;
    assign hit        = wr_en && (idx == IDX_W'(i));
    assign req_vec[i] = hit & ~wdat;
    assign rel_vec[i] = hit &  wdat;
  end

endmodule

// File: rtl/sem_cell.sv
module sem_cell
  import sem_bank_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic l_req,
  input  logic l_rel,
  input  logic r_req,
  input  logic r_rel,
  output logic own_l,
  output logic own_r
);

  owner_t st, st_n;
  logic   pend, pend_n;

  always_comb begin
    st_n   = st;
    pend_n = pend;
    case (st)
      SEM_FREE: begin
        if (l_req) begin
          st_n   = SEM_LEFT;
          pend_n = r_req;
        end else if (r_req) begin
          st_n   = SEM_RIGHT;
          pend_n = 1'b0;
        end
      end
      SEM_LEFT: begin
        if (r_req)      pend_n = 1'b1;
        else if (r_rel) pend_n = 1'b0;
        if (l_rel) begin
          st_n   = pend_n ? SEM_RIGHT : SEM_FREE;
          pend_n = 1'b0;
        end
      end
      SEM_RIGHT: begin
        if (l_req)      pend_n = 1'b1;
        else if (l_rel) pend_n = 1'b0;
        if (r_rel) begin
          st_n   = pend_n ? SEM_LEFT : SEM_FREE;
          pend_n = 1'b0;
        end
      end
      default: begin
        st_n   = SEM_FREE;
        pend_n = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= SEM_FREE;
      pend <= 1'b0;
    end else begin
      st   <= st_n;
      pend <= pend_n;
    end
  end

  assign own_l = (st == SEM_LEFT);
  assign own_r = (st == SEM_RIGHT);

endmodule

// File: rtl/sem_rd_port.sv
module sem_rd_port #(
  parameter int NUM_SEM = 8,
  parameter int RD_W    = 9,
  localparam int IDX_W  = $clog2(NUM_SEM)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rd_en,
  input  logic [IDX_W-1:0]   idx,
  input  logic [NUM_SEM-1:0] own_vec,
  output logic [RD_W-1:0]    rdat
);

  logic flag;

  assign flag = ~own_vec[idx];

  always_ff @(posedge clk) begin
    if (rst)        rdat <= '1;
    else if (rd_en) rdat <= {RD_W{flag}};
  end

endmodule

// File: rtl/sem_bank.sv
module sem_bank #(
  parameter int NUM_SEM = 8,
  parameter int RD_W    = 9,
  localparam int IDX_W  = $clog2(NUM_SEM)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             l_sel,
  input  logic             l_wr,
  input  logic [IDX_W-1:0] l_idx,
  input  logic             l_wdat,
  output logic [RD_W-1:0]  l_rdat,
  input  logic             r_sel,
  input  logic             r_wr,
  input  logic [IDX_W-1:0] r_idx,
  input  logic             r_wdat,
  output logic [RD_W-1:0]  r_rdat
);

  logic [NUM_SEM-1:0] l_req_vec, l_rel_vec, r_req_vec, r_rel_vec;
  logic [NUM_SEM-1:0] own_l_vec, own_r_vec;
  logic               l_rd_en, r_rd_en;

  sem_port_dec #(.NUM_SEM(NUM_SEM)) u_dec_l (
    .sel(l_sel), .wr(l_wr), .idx(l_idx), .wdat(l_wdat),
    .req_vec(l_req_vec), .rel_vec(l_rel_vec), .rd_en(l_rd_en)
  );

  sem_port_dec #(.NUM_SEM(NUM_SEM)) u_dec_r (
    .sel(r_sel), .wr(r_wr), .idx(r_idx), .wdat(r_wdat),
    .req_vec(r_req_vec), .rel_vec(r_rel_vec), .rd_en(r_rd_en)
  );

  for (genvar i = 0; i < NUM_SEM; i++) begin : g_cell
    sem_cell u_cell (
      .clk  (clk),
      .rst  (rst),
      .l_req(l_req_vec[i]),
      .l_rel(l_rel_vec[i]),
      .r_req(r_req_vec[i]),
      .r_rel(r_rel_vec[i]),
      .own_l(own_l_vec[i]),
      .own_r(own_r_vec[i])
    );
  end

  sem_rd_port #(.NUM_SEM(NUM_SEM), .RD_W(RD_W)) u_rd_l (
    .clk(clk), .rst(rst), .rd_en(l_rd_en), .idx(l_idx),
    .own_vec(own_l_vec), .rdat(l_rdat)
  );

  sem_rd_port #(.NUM_SEM(NUM_SEM), .RD_W(RD_W)) u_rd_r (
    .clk(clk), .rst(rst), .rd_en(r_rd_en), .idx(r_idx),
    .own_vec(own_r_vec), .rdat(r_rdat)
  );

endmodule

// File: rtl/sem_bank_chk.sv
module sem_bank_chk #(
  parameter int NUM_SEM = 8,
  parameter int RD_W    = 9,
  localparam int IDX_W  = $clog2(NUM_SEM)
) (
  input logic               clk,
  input logic               rst,
  input logic               l_sel,
  input logic               l_wr,
  input logic [IDX_W-1:0]   l_idx,
  input logic               l_wdat,
  input logic [RD_W-1:0]    l_rdat,
  input logic               r_sel,
  input logic               r_wr,
  input logic [IDX_W-1:0]   r_idx,
  input logic               r_wdat,
  input logic [RD_W-1:0]    r_rdat,
  input logic [NUM_SEM-1:0] own_l_vec,
  input logic [NUM_SEM-1:0] own_r_vec
);

  logic both_rd_same, both_req_free;

  assign both_rd_same  = l_sel && !l_wr && r_sel && !r_wr && (l_idx == r_idx);
  assign both_req_free = l_sel && l_wr && !l_wdat && r_sel && r_wr && !r_wdat &&
                         (l_idx == r_idx) && !own_l_vec[l_idx] && !own_r_vec[l_idx];

  AST_LANE_L: assert property (@(posedge clk) disable iff (rst)
    (l_rdat == '0) || (l_rdat == '1)); // R11
  AST_LANE_R: assert property (@(posedge clk) disable iff (rst)
    (r_rdat == '0) || (r_rdat == '1)); // R11
  AST_NO_DUAL_OWNER: assert property (@(posedge clk) disable iff (rst)
    both_rd_same |=> !((l_rdat == '0) && (r_rdat == '0))); // R9
  AST_HOLD_L: assert property (@(posedge clk) disable iff (rst)
    !(l_sel && !l_wr) |=> $stable(l_rdat)); // R10
  AST_HOLD_R: assert property (@(posedge clk) disable iff (rst)
    !(r_sel && !r_wr) |=> $stable(r_rdat)); // R10
  AST_TIE_LEFT: assert property (@(posedge clk) disable iff (rst)
    both_req_free |=> own_l_vec[$past(l_idx)]); // R9

endmodule

bind sem_bank sem_bank_chk #(.NUM_SEM(NUM_SEM), .RD_W(RD_W)) u_chk (
  .clk(clk), .rst(rst),
  .l_sel(l_sel), .l_wr(l_wr), .l_idx(l_idx), .l_wdat(l_wdat), .l_rdat(l_rdat),
  .r_sel(r_sel), .r_wr(r_wr), .r_idx(r_idx), .r_wdat(r_wdat), .r_rdat(r_rdat),
  .own_l_vec(own_l_vec), .own_r_vec(own_r_vec)
);

// File: tb/sem_bank_bench.sv
module sem_bank_bench;

  localparam int CLK_P = 10;
  localparam int NS    = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       l_sel = 0, l_wr = 0, l_wdat = 0;
  logic       r_sel = 0, r_wr = 0, r_wdat = 0;
  logic [2:0] l_idx = 0, r_idx = 0;
  logic [8:0] l_rdat, r_rdat;

  int checks = 0;
  int failures = 0;

  // model: 0 free, 1 left owns, 2 right owns
  int   own [NS];
  logic pend [NS];
  logic [8:0] exp_l, exp_r;

  always #(CLK_P/2) clk = ~clk;

  sem_bank u_sem_bank (
    .clk(clk), .rst(rst),
    .l_sel(l_sel), .l_wr(l_wr), .l_idx(l_idx), .l_wdat(l_wdat), .l_rdat(l_rdat),
    .r_sel(r_sel), .r_wr(r_wr), .r_idx(r_idx), .r_wdat(r_wdat), .r_rdat(r_rdat)
  );

  task automatic check(input logic [8:0] act, input logic [8:0] expv,
                       input string tag, input string side);
    checks++;
    if (act !== expv) begin
      failures++;
      $display("FAIL %s port %s actual=%h expected=%h", tag, side, act, expv);
    end
  endtask

  task automatic model_update(input logic ls, lw, input logic [2:0] la, input logic ld,
                              input logic rs, rw, input logic [2:0] ra, input logic rd);
    for (int i = 0; i < NS; i++) begin
      logic wl, wr_, rql, rll, rqr, rlr;
      wl  = ls && lw && (la == 3'(i));
      wr_ = rs && rw && (ra == 3'(i));
      rql = wl && !ld;  rll = wl && ld;
      rqr = wr_ && !rd; rlr = wr_ && rd;
      case (own[i])
        0: begin
          if (rql) begin own[i] = 1; pend[i] = rqr; end
          else if (rqr) begin own[i] = 2; pend[i] = 1'b0; end
        end
        1: begin
          if (rqr) pend[i] = 1'b1; else if (rlr) pend[i] = 1'b0;
          if (rll) begin own[i] = pend[i] ? 2 : 0; pend[i] = 1'b0; end
        end
        default: begin
          if (rql) pend[i] = 1'b1; else if (rll) pend[i] = 1'b0;
          if (rlr) begin own[i] = pend[i] ? 1 : 0; pend[i] = 1'b0; end
        end
      endcase
    end
  endtask

  // called at a falling edge; returns at the next falling edge after checking
  task automatic step(input logic ls, lw, input logic [2:0] la, input logic ld,
                      input logic rs, rw, input logic [2:0] ra, input logic rd,
                      input string tag);
    l_sel = ls; l_wr = lw; l_idx = la; l_wdat = ld;
    r_sel = rs; r_wr = rw; r_idx = ra; r_wdat = rd;
    if (ls && !lw) exp_l = (own[la] == 1) ? 9'h000 : 9'h1FF;
    if (rs && !rw) exp_r = (own[ra] == 2) ? 9'h000 : 9'h1FF;
    model_update(ls, lw, la, ld, rs, rw, ra, rd);
    @(posedge clk);
    @(negedge clk);
    check(l_rdat, exp_l, tag, "L");
    check(r_rdat, exp_r, tag, "R");
  endtask

  task automatic rd_both(input logic [2:0] a, input string tag);
    step(1, 0, a, 0, 1, 0, a, 0, tag);
  endtask

  initial begin
    #(CLK_P * 200000);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    for (int i = 0; i < NS; i++) begin own[i] = 0; pend[i] = 1'b0; end
    exp_l = 9'h1FF; exp_r = 9'h1FF;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check(l_rdat, 9'h1FF, "R1", "L");
    check(r_rdat, 9'h1FF, "R1", "R");
    for (int i = 0; i < NS; i++) rd_both(3'(i), "R1");

    // R2 / R3: claim latch 3 on the left
    step(1, 1, 3'd3, 0, 0, 0, 3'd0, 0, "R3");
    rd_both(3'd3, "R3");
    rd_both(3'd4, "R2");
    // R4: right claims while left owns
    step(0, 0, 3'd0, 0, 1, 1, 3'd3, 0, "R4");
    rd_both(3'd3, "R4");
    // R5: left releases, right takes over
    step(1, 1, 3'd3, 1, 0, 0, 3'd0, 0, "R5");
    rd_both(3'd3, "R5");
    // R6: right releases with nothing pending
    step(0, 0, 3'd0, 0, 1, 1, 3'd3, 1, "R6");
    rd_both(3'd3, "R6");
    // R7: cancel pending claim on latch 5
    step(0, 0, 3'd0, 0, 1, 1, 3'd5, 0, "R7");
    step(1, 1, 3'd5, 0, 0, 0, 3'd0, 0, "R7");
    step(1, 1, 3'd5, 1, 0, 0, 3'd0, 0, "R7");
    step(0, 0, 3'd0, 0, 1, 1, 3'd5, 1, "R7");
    rd_both(3'd5, "R7");
    // R8: stray releases ignored
    step(1, 1, 3'd2, 1, 0, 0, 3'd0, 0, "R8");
    rd_both(3'd2, "R8");
    step(0, 0, 3'd0, 0, 1, 1, 3'd2, 0, "R8");
    step(1, 1, 3'd2, 1, 0, 0, 3'd0, 0, "R8");
    rd_both(3'd2, "R8");
    step(0, 0, 3'd0, 0, 1, 1, 3'd2, 1, "R8");
    rd_both(3'd2, "R8");
    // R9: simultaneous claim on free latch 6
    step(1, 1, 3'd6, 0, 1, 1, 3'd6, 0, "R9");
    rd_both(3'd6, "R9");
    step(1, 1, 3'd6, 1, 0, 0, 3'd0, 0, "R9");
    rd_both(3'd6, "R9");
    // R10: left pending on 6 (right owns); left reads while right releases
    step(1, 1, 3'd6, 0, 0, 0, 3'd0, 0, "R10");
    step(1, 0, 3'd6, 0, 1, 1, 3'd6, 1, "R10");
    check(l_rdat, 9'h1FF, "R10", "L");
    step(0, 0, 3'd0, 0, 0, 0, 3'd0, 0, "R10");
    check(l_rdat, 9'h1FF, "R10", "L");
    step(1, 0, 3'd6, 0, 0, 0, 3'd0, 0, "R10");
    check(l_rdat, 9'h000, "R11", "L");
    step(1, 1, 3'd6, 1, 0, 0, 3'd0, 0, "R6");

    // R12 sweep: pseudo-random traffic, frequent shared index
    lfsr = 16'hACE1;
    for (int n = 0; n < 4000; n++) begin
      logic [2:0] ra;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      ra = lfsr[6] ? lfsr[4:2] : lfsr[9:7];
      step(lfsr[0] | lfsr[11], lfsr[1], lfsr[4:2], lfsr[5],
           lfsr[10] | lfsr[14], lfsr[12], ra, lfsr[13], "R12");
    end
    for (int i = 0; i < NS; i++) rd_both(3'(i), "R12");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule